// File: doc/BRIEF.md
# Multi-Clock Health Monitor

This block watches up to four clocks against one reference clock that is assumed clean and stable. It reports three kinds of run-time fault for each watched clock. A clock has stopped when no edge has arrived for a set number of reference cycles. A clock is out of tolerance when the number of its edges counted over a fixed measurement window misses its nominal count by more than a set margin. A clock has glitched when that count rises far above nominal, which is what extra narrow pulses on the line produce. Every fault class drives its own 4-bit discrete output, with one bit for each watched clock.

Each watched clock toggles a flop in its own domain. The toggle passes through a synchronizer into the reference domain, where its transitions are counted. The nominal counts come from the reference frequency, the watched frequencies and the window length, all of which are parameters. The tolerance and the glitch margin are parameters given as percentages of nominal. A bus master on an AXI4-Lite slave port reads sticky copies of all fault bits, clears them by writing ones, and chooses which faults may drive the interrupt line.

Top module: `clkmon_top`

## Requirements
- R1: Stop bit i (stop_flags[i]) rises once clock i has produced no edge for STOP_LEN reference cycles. It falls again after the first edge that arrives through the synchronizer.
- R2: At each window close, the out-of-tolerance bit i (oor_flags[i]) is loaded with 1 if clock i's edge count was below nominal minus tolerance or above nominal plus tolerance, and with 0 otherwise. The bit keeps that value until the next window close.
- R3: At each window close, glitch bit i (glitch_flags[i]) is loaded with 1 if clock i's edge count exceeded nominal plus the glitch margin. The glitch margin is not smaller than the tolerance, so a glitched clock is also out of tolerance.
- R4: The status register at byte offset 0x0 holds sticky copies of the faults. Bits [3:0] are stop, bits [7:4] are glitch, bits [11:8] are out-of-tolerance, and bit 4k+i or 8+i belongs to clock i. A bit is set in every cycle in which its live fault is present. Bits [31:12] read 0.
- R5: Writing 1 to a status bit clears it. If the live fault is present in that same cycle, the bit stays set. Writing 0 leaves the bit unchanged.
- R6: The enable mask register at byte offset 0x4 is read-write in bits [11:0], which use the same layout as the status register. Bits [31:12] ignore writes and read 0.
- R7: irq is high exactly when some status bit is set together with its mask bit. A mask of zero holds irq low whatever the faults.
- R8: After reset, all discrete outputs, irq, the status register and the mask register are 0. They stay 0 until the first window closes or the stop timeout elapses.
- R9: Every AXI4-Lite write and read completes with response OKAY (2'b00). A read of an unmapped offset (0x8, 0xC) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for measurement and bus |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_clk | input | 4 | Watched clocks, bit i is clock i |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| stop_flags | output | 4 | Live stop fault for each clock |
| glitch_flags | output | 4 | Live glitch fault for each clock |
| oor_flags | output | 4 | Live out-of-tolerance fault for each clock |
| irq | output | 1 | Masked interrupt |

## Verification
Two pairs of faults can be raised at the same window close. A clock that runs far too fast raises both glitch and out-of-tolerance, and a clock that has died raises both stop and out-of-tolerance (its count is zero). The bench provokes both cases, each in a table row of its own, and in a mixed row with different clocks in different states. In every row it checks that each discrete vector and the packed status word show both bits for the affected clock and none for the others. A second clash occurs when a write-one-to-clear meets a fault that is still present. The bench issues the clear while a clock is stopped and expects the stop bit to read back as still set.

// File: rtl/clkmon_pkg.sv
// Package: shared constants and the packed fault layout for the clock monitor.
// Assumes at most four watched clocks; the struct order fixes register bits.
package clkmon_pkg;
    localparam int MAX_CLK  = 4;
    localparam int FLT_W    = 3 * MAX_CLK;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;
    localparam logic [1:0] IDX_STATUS = 2'd0;
    localparam logic [1:0] IDX_MASK   = 2'd1;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    typedef struct packed {
        logic [MAX_CLK-1:0] oor;
        logic [MAX_CLK-1:0] glitch;
        logic [MAX_CLK-1:0] stop;
    } fault_vec_t;
endpackage

// File: rtl/clkmon_edge_sync.sv
// Edge transfer: a toggle flop in the watched domain is resynchronized into
// the reference domain, and every toggle transition becomes a one-cycle pulse.
// Assumes the watched clock is slower than the reference clock, so that the
// toggle changes no more than once per reference cycle.
module clkmon_edge_sync (
    input  logic mon_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic edge_pulse
);
    logic       tgl_q;
    logic [2:0] sync_q;

    // Watched domain: flip once per watched rising edge
    always_ff @(posedge mon_clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    // Reference domain: two synchronizer stages plus one history stage
    always_ff @(posedge ref_clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], tgl_q};
    end

    assign edge_pulse = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/clkmon_timebase.sv
// Window timebase: issues a one-cycle win_end pulse every WIN_LEN reference
// cycles. All channels share it, so their windows are aligned.
module clkmon_timebase #(
    parameter int WIN_LEN = 64
) (
    input  logic ref_clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int TB_W = $clog2(WIN_LEN);
    localparam logic [TB_W-1:0] LAST = TB_W'(WIN_LEN - 1);

    logic [TB_W-1:0] tick_q;

    // Free-running window position counter
    always_ff @(posedge ref_clk) begin
        if (!rst_n)              tick_q <= '0;
        else if (tick_q == LAST) tick_q <= '0;
        else                     tick_q <= tick_q + 1'b1;
    end

    assign win_end = (tick_q == LAST);
endmodule

// File: rtl/clkmon_channel.sv
// One watched clock: counts synchronized edges per window, judges the count
// against nominal limits, and times the gap since the last edge.
// Assumes GLITCH_MARGIN >= TOL, so a glitch implies out-of-tolerance.
module clkmon_channel #(
    parameter int NOM           = 16,
    parameter int TOL           = 2,
    parameter int GLITCH_MARGIN = 8,
    parameter int CNT_W         = 7,
    parameter int STOP_LEN      = 32
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic edge_pulse,
    input  logic win_end,
    output logic stop_o,
    output logic glitch_o,
    output logic oor_o
);
    localparam int LO_LIM  = (NOM > TOL) ? NOM - TOL : 0;
    localparam int HI_LIM  = NOM + TOL;
    localparam int GL_LIM  = NOM + GLITCH_MARGIN;
    localparam int STOP_W  = $clog2(STOP_LEN);
    localparam logic [STOP_W-1:0] IDLE_LAST = STOP_W'(STOP_LEN - 1);

    logic [CNT_W-1:0]  edge_cnt_q;
    logic [STOP_W-1:0] idle_q;
    logic              stop_q, glitch_q, oor_q;
    int                cnt_i;

    assign cnt_i = int'(edge_cnt_q);

    // Edge count of the current window, restarted at each close
    always_ff @(posedge ref_clk) begin
        if (!rst_n)
            edge_cnt_q <= '0;
        else if (win_end)
            edge_cnt_q <= CNT_W'(edge_pulse);
        else if (edge_pulse && (edge_cnt_q != '1))
            edge_cnt_q <= edge_cnt_q + 1'b1;
    end

    // Count judgement, loaded once per window
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            oor_q    <= 1'b0;
            glitch_q <= 1'b0;
        end else if (win_end) begin
            oor_q    <= (cnt_i < LO_LIM) || (cnt_i > HI_LIM);
            glitch_q <= (cnt_i > GL_LIM);
        end
    end

    // Gap timer: stop raised after STOP_LEN quiet cycles, dropped on an edge
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            idle_q <= '0;
            stop_q <= 1'b0;
        end else if (edge_pulse) begin
            idle_q <= '0;
            stop_q <= 1'b0;
        end else if (idle_q == IDLE_LAST) begin
            stop_q <= 1'b1;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign stop_o   = stop_q;
    assign glitch_o = glitch_q;
    assign oor_o    = oor_q;
endmodule

// File: rtl/clkmon_regs.sv
// AXI4-Lite register file: a sticky write-one-to-clear status word and an
// enable mask, plus the masked interrupt. Address and data of a write must be
// presented together; one transaction of each kind is outstanding at a time.
module clkmon_regs
    import clkmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLT_W-1:0]  live,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [FLT_W-1:0]  status_o,
    output logic [FLT_W-1:0]  mask_o,
    output logic              irq
);
    logic [FLT_W-1:0]  status_q, mask_q, byte_en, wbits;
    logic [DATA_W-1:0] rd_word;
    logic              wr_go, rd_go, wr_stat, wr_mask;
    logic              unused_bits;

    assign s_awready = s_awvalid && s_wvalid && !s_bvalid;
    assign s_wready  = s_awready;
    assign wr_go     = s_awready;
    assign rd_go     = s_arvalid && s_arready;
    assign s_arready = !s_rvalid;
    assign wr_stat   = wr_go && (s_awaddr[3:2] == IDX_STATUS);
    assign wr_mask   = wr_go && (s_awaddr[3:2] == IDX_MASK);
    assign byte_en   = {{(FLT_W-8){s_wstrb[1]}}, {8{s_wstrb[0]}}};
    assign wbits     = s_wdata[FLT_W-1:0] & byte_en;
    assign unused_bits = ^{s_wdata[DATA_W-1:FLT_W], s_wstrb[3:2],
                           s_awaddr[1:0], s_araddr[1:0]};

    // Sticky status: clear by written ones, live faults always win
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (wr_stat) status_q <= (status_q & ~wbits) | live;
        else              status_q <= status_q | live;
    end

    // Interrupt enable mask, byte-strobed
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= (mask_q & ~byte_en) | wbits;
    end

    // Write response channel
    always_ff @(posedge clk) begin
        if (!rst_n)        s_bvalid <= 1'b0;
        else if (wr_go)    s_bvalid <= 1'b1;
        else if (s_bready) s_bvalid <= 1'b0;
    end

    // Read data selection
    always_comb begin
        rd_word = '0;
        case (s_araddr[3:2])
            IDX_STATUS: rd_word[FLT_W-1:0] = status_q;
            IDX_MASK:   rd_word[FLT_W-1:0] = mask_q;
            default:    rd_word = '0;
        endcase
    end

    // Read data channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rd_go) begin
            s_rvalid <= 1'b1;
            s_rdata  <= rd_word;
        end else if (s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    assign s_bresp  = RESP_OKAY;
    assign s_rresp  = RESP_OKAY;
    assign irq      = |(status_q & mask_q);
    assign status_o = status_q;
    assign mask_o   = mask_q;
endmodule

// File: rtl/clkmon_top.sv
// Multi-clock health monitor top: one edge synchronizer and one judging
// channel per watched clock, a shared window timebase, and the register file.
// Nominal counts derive from REF_HZ, MON_HZ and WIN_LEN; limits are percents.
module clkmon_top
    import clkmon_pkg::*;
#(
    parameter int     NUM_CLK    = 4,
    parameter longint REF_HZ     = 200_000_000,
    parameter longint MON_HZ [MAX_CLK] = '{50_000_000, 50_000_000,
                                           50_000_000, 50_000_000},
    parameter int     WIN_LEN    = 64,
    parameter int     TOL_PCT    = 15,
    parameter int     GLITCH_PCT = 50,
    parameter int     STOP_LEN   = 32
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic [MAX_CLK-1:0] mon_clk,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [MAX_CLK-1:0] stop_flags,
    output logic [MAX_CLK-1:0] glitch_flags,
    output logic [MAX_CLK-1:0] oor_flags,
    output logic              irq
);
    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic       win_end;
    fault_vec_t live;
    logic [FLT_W-1:0] status_w, mask_w;

    clkmon_timebase #(.WIN_LEN(WIN_LEN)) u_tb (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar g = 0; g < MAX_CLK; g++) begin : g_ch
        if (g < NUM_CLK) begin : g_on
            localparam int NOM_G = int'((MON_HZ[g] * longint'(WIN_LEN)) / REF_HZ);
            localparam int TOL_G = (NOM_G * TOL_PCT) / 100;
            localparam int GLM_G = (NOM_G * GLITCH_PCT) / 100;
            logic edge_p;

            clkmon_edge_sync u_sync (
                .mon_clk    (mon_clk[g]),
                .ref_clk    (ref_clk),
                .rst_n      (rst_n),
                .edge_pulse (edge_p)
            );

            clkmon_channel #(
                .NOM           (NOM_G),
                .TOL           (TOL_G),
                .GLITCH_MARGIN (GLM_G),
                .CNT_W         (CNT_W),
                .STOP_LEN      (STOP_LEN)
            ) u_ch (
                .ref_clk    (ref_clk),
                .rst_n      (rst_n),
                .edge_pulse (edge_p),
                .win_end    (win_end),
                .stop_o     (live.stop[g]),
                .glitch_o   (live.glitch[g]),
                .oor_o      (live.oor[g])
            );
        end else begin : g_off
            assign live.stop[g]   = 1'b0;
            assign live.glitch[g] = 1'b0;
            assign live.oor[g]    = 1'b0;
        end
    end

    clkmon_regs u_regs (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .live      (live),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .status_o  (status_w),
        .mask_o    (mask_w),
        .irq       (irq)
    );

    assign stop_flags   = live.stop;
    assign glitch_flags = live.glitch;
    assign oor_flags    = live.oor;
endmodule

// File: rtl/clkmon_checker.sv
// Property checker for clkmon_top, attached by bind. Observes ports and the
// status/mask registers; holds no state of its own.
module clkmon_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] status_q,
    input logic [11:0] mask_q,
    input logic [11:0] live,
    input logic        win_end,
    input logic [3:0]  glitch_flags,
    input logic [3:0]  oor_flags,
    input logic        irq,
    input logic [3:0]  awaddr,
    input logic        awvalid,
    input logic        awready,
    input logic        bvalid,
    input logic        bready,
    input logic        rvalid,
    input logic        rready,
    input logic [31:0] rdata
);
    // R5: without a status write, no sticky bit is lost
    a_r5_sticky_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(awvalid && awready && awaddr[3:2] == 2'd0)
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R4: a live fault is captured in status on the next edge
    a_r4_live_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (live != 12'd0) |=> ((status_q & $past(live)) == $past(live)));

    // R2: window judgements change only after a window close
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable({glitch_flags, oor_flags}));

    // R3: a glitched clock is also out of tolerance
    a_r3_glitch_in_oor: assert property (@(posedge clk) disable iff (!rst_n)
        ((glitch_flags & ~oor_flags) == 4'd0));

    // R7: an empty mask silences the interrupt
    a_r7_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 12'd0) |-> !irq);

    // R9: write response held until taken
    a_r9_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    // R9: read data held stable until taken
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

bind clkmon_top clkmon_checker u_chk (
    .clk          (ref_clk),
    .rst_n        (rst_n),
    .status_q     (status_w),
    .mask_q       (mask_w),
    .live         (live),
    .win_end      (win_end),
    .glitch_flags (glitch_flags),
    .oor_flags    (oor_flags),
    .irq          (irq),
    .awaddr       (s_awaddr),
    .awvalid      (s_awvalid),
    .awready      (s_awready),
    .bvalid       (s_bvalid),
    .bready       (s_bready),
    .rvalid       (s_rvalid),
    .rready       (s_rready),
    .rdata        (s_rdata)
);

// File: tb/clkmon_top_tb_top.sv
`timescale 1ns/1ps
module clkmon_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc0 = 1'b0, mc1 = 1'b0, mc2 = 1'b0, mc3 = 1'b0;
    int          half [4] = '{10, 10, 10, 10};
    logic [3:0]  awaddr = '0, araddr = '0, wstrb = '0;
    logic [31:0] wdata = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic        awready, wready, bvalid, arready, rvalid, irq;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [3:0]  stop_f, glitch_f, oor_f;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;   // 200 MHz reference

    // Watched clocks; a half period of 0 holds the clock still
    always begin if (half[0] == 0) #5; else begin #(half[0]); mc0 = ~mc0; end end
    always begin if (half[1] == 0) #5; else begin #(half[1]); mc1 = ~mc1; end end
    always begin if (half[2] == 0) #5; else begin #(half[2]); mc2 = ~mc2; end end
    always begin if (half[3] == 0) #5; else begin #(half[3]); mc3 = ~mc3; end end

    clkmon_top dut_i (
        .ref_clk (clk), .rst_n (rst_n), .mon_clk ({mc3, mc2, mc1, mc0}),
        .s_awaddr (awaddr), .s_awvalid (awvalid), .s_awready (awready),
        .s_wdata (wdata), .s_wstrb (wstrb), .s_wvalid (wvalid), .s_wready (wready),
        .s_bresp (bresp), .s_bvalid (bvalid), .s_bready (bready),
        .s_araddr (araddr), .s_arvalid (arvalid), .s_arready (arready),
        .s_rdata (rdata), .s_rresp (rresp), .s_rvalid (rvalid), .s_rready (rready),
        .stop_flags (stop_f), .glitch_flags (glitch_f), .oor_flags (oor_f),
        .irq (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic axi_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        check("R9 bresp", {30'd0, bresp}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1; rready = 1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 0; d = rdata;
        check("R9 rresp", {30'd0, rresp}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        rready = 0;
    endtask

    task automatic settle();
        repeat (2 * 64 + 10) @(posedge clk);
        @(negedge clk);
    endtask

    // Table row: {half3, half2, half1, half0, stop, glitch, oor}
    localparam logic [43:0] VECS [6] = '{
        {8'd10, 8'd10, 8'd10, 8'd10, 4'b0000, 4'b0000, 4'b0000},
        {8'd10, 8'd10, 8'd10, 8'd4,  4'b0000, 4'b0001, 4'b0001},
        {8'd10, 8'd10, 8'd14, 8'd10, 4'b0000, 4'b0000, 4'b0010},
        {8'd10, 8'd0,  8'd10, 8'd10, 4'b0100, 4'b0000, 4'b0100},
        {8'd0,  8'd10, 8'd4,  8'd14, 4'b1000, 4'b0010, 4'b1011},
        {8'd10, 8'd10, 8'd10, 8'd10, 4'b0000, 4'b0000, 4'b0000}
    };

    initial begin
        logic [31:0] rd;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R8: reset state, before any window closes
        check("R8 stop", {28'd0, stop_f}, 0);
        check("R8 glitch", {28'd0, glitch_f}, 0);
        check("R8 oor", {28'd0, oor_f}, 0);
        check("R8 irq", {31'd0, irq}, 0);
        axi_read(4'h0, rd); check("R8 status", rd, 0);
        axi_read(4'h4, rd); check("R8 mask", rd, 0);

        // R1 R2 R3 R4: table walk
        for (int v = 0; v < 6; v++) begin
            logic [43:0] row;
            row = VECS[v];
            half[3] = int'(row[43:36]); half[2] = int'(row[35:28]);
            half[1] = int'(row[27:20]); half[0] = int'(row[19:12]);
            settle();
            axi_write(4'h0, 32'hFFF);
            settle();
            check("R1 stop_flags", {28'd0, stop_f}, {28'd0, row[11:8]});
            check("R3 glitch_flags", {28'd0, glitch_f}, {28'd0, row[7:4]});
            check("R2 oor_flags", {28'd0, oor_f}, {28'd0, row[3:0]});
            axi_read(4'h0, rd);
            check("R4 status word", rd, {20'd0, row[3:0], row[7:4], row[11:8]});
        end

        // R6: mask read-write, upper bits read zero
        axi_write(4'h4, 32'hFFFF_FFFF);
        axi_read(4'h4, rd); check("R6 mask readback", rd, 32'h0000_0FFF);
        // R7: all clocks healthy, status clear -> no interrupt
        axi_write(4'h0, 32'hFFF);
        @(negedge clk);
        check("R7 irq quiet", {31'd0, irq}, 0);
        // R7: stop clock 2 -> interrupt
        half[2] = 0;
        settle();
        check("R7 irq on stop", {31'd0, irq}, 1);
        axi_write(4'h4, 32'h0000_0004);
        @(negedge clk);
        check("R7 irq stop bit only", {31'd0, irq}, 1);
        axi_write(4'h4, 32'h0000_0000);
        @(negedge clk);
        check("R7 irq masked", {31'd0, irq}, 0);
        // R5: clear while fault persists -> stop bit 2 stays set
        axi_write(4'h0, 32'hFFF);
        axi_read(4'h0, rd); check("R5 clear loses to live", rd & 32'h4, 32'h4);
        // R5: writing zero leaves status unchanged
        axi_write(4'h0, 32'h0);
        axi_read(4'h0, rd); check("R5 write zero keeps", rd, 32'h0000_0404);
        // R9: unmapped offsets read zero
        axi_read(4'h8, rd); check("R9 unmapped 0x8", rd, 0);
        axi_read(4'hC, rd); check("R9 unmapped 0xC", rd, 0);
        // R1: restart clock 2 -> stop drops, status clears cleanly
        half[2] = 10;
        settle();
        check("R1 stop released", {28'd0, stop_f}, 0);
        axi_write(4'h0, 32'hFFF);
        axi_read(4'h0, rd); check("R5 clear takes effect", rd, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule